// File: doc/BRIEF.md
# Queued SPI Command Sequencer

This block is an SPI master that works through a queue of transfer commands instead of one byte at a time. Software fills a 16-entry command memory, one entry per transfer. Each entry holds a transmit byte and the chip-select pattern to drive while that byte is on the wire. Software then programs a 16-bit control word with the first and last queue positions and pulses `start`. The sequencer runs one 8-bit SPI transfer per entry and writes each received byte into a receive memory at the same index. It keeps a read-only field that reports the last entry it finished.

Execution can loop. With wrap enabled, the entry after the last one is either entry 0 or the programmed first entry. A halt bit stops the queue cleanly once the command in progress has finished. The idle level of the chip selects is programmable, so the block serves both active-high and active-low slaves. `done` pulses when a run ends.

Top module: `spi_queue_seq`

## Requirements
- R1: After reset the control word reads 0x0000, `csOut` is 0, `sck` is 0 and `done` is 0.
- R2: Control word layout: bit 15 halt, bit 14 wrap enable, bit 13 wrap target, bit 12 chip-select idle level, bits 11:8 last entry, bits 7:4 completed entry, bits 3:0 first entry. Bits 7:4 are read-only, and writes to them are ignored.
- R3: When `start` is pulsed while the sequencer is idle and halt is 0, it runs entries from the first entry up to and including the last entry. Each entry is one SPI mode 0 transfer of 8 bits, MSB first, with SCK at the system clock divided by 4 (2 cycles low, 2 cycles high). SCK stays low while idle.
- R4: During an entry's transfer, `csOut` equals bits 11:8 of that entry. While idle, `csOut` equals the idle-level bit copied to all 4 lines.
- R5: The byte received on `miso` during an entry's transfer is stored at the same index in the receive memory, readable through `rxRaddr`/`rxRdata`.
- R6: Without a wrap, the entry pointer advances modulo 16, so a last entry below the first entry gives a valid queue that passes entry 15 and then entry 0.
- R7: After each transfer, bits 7:4 of the control word hold the index of that entry.
- R8: With wrap enabled and wrap target 0, the entry after the last entry is entry 0, and execution continues.
- R9: With wrap enabled and wrap target 1, the entry after the last entry is the first entry.
- R10: Setting halt during a run stops execution after the current transfer completes. `start` is ignored while halt is 1. After halt is cleared, `start` restarts from the first entry.
- R11: `done` pulses high for exactly one cycle when the queue ends without a wrap or stops on halt. It is never high while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Control word write strobe |
| regWdata | input | 16 | Control word write data |
| regRdata | output | 16 | Control word read value |
| ramWe | input | 1 | Command memory write strobe |
| ramWaddr | input | 4 | Command memory write index |
| ramWdata | input | 12 | Entry: [11:8] chip-select pattern, [7:0] transmit byte |
| rxRaddr | input | 4 | Receive memory read index |
| rxRdata | output | 8 | Receive memory read data (combinational) |
| start | input | 1 | Start pulse |
| done | output | 1 | One-cycle end-of-run pulse |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| csOut | output | 4 | Chip-select outputs |

## Verification
The bench sweeps every first entry with queue lengths 1 to 3, under both idle levels. This covers queues that cross from entry 15 to entry 0. A pointer that saturated, or that compared the last entry wrongly, would send the wrong bytes or never stop. Both wrap targets are run with a halt raised mid-queue. A design that stopped at once, or ignored the target select, would produce a different entry order or count. A write of ones into the completed-entry field checks that it stays read-only. A start issued while halt is set checks that a halted sequencer does not creep forward.

// File: rtl/spi_queue_pkg.sv
package spi_queue_pkg;
  localparam int ENTRIES = 16;
  localparam int PTR_W   = $clog2(ENTRIES);
  localparam int DATA_W  = 8;
  localparam int CS_W    = 4;
  localparam int ENTRY_W = DATA_W + CS_W;
  localparam int BIT_W   = $clog2(DATA_W);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_FIN} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // fetch entry into shifter and chip-select register
    logic sample;  // capture miso (SCK about to rise)
    logic shift;   // advance transmit shifter (SCK about to fall)
    logic commit;  // store received byte
  } dpStrobe_t;

  typedef struct packed {
    logic             halt;
    logic             wren;
    logic             wrto;
    logic             csiv;
    logic [PTR_W-1:0] endQ;
    logic [PTR_W-1:0] cptQ;
    logic [PTR_W-1:0] newQ;
  } ctrlReg_t;
endpackage

// File: rtl/spi_queue_ctrl.sv
module spi_queue_ctrl
  import spi_queue_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [15:0]      regWdata,
  output logic [15:0]      regRdata,
  input  logic             start,
  output dpStrobe_t        strobe,
  output logic [PTR_W-1:0] ptr,
  output logic             busy,
  output logic             csIdle,
  output logic             sck,
  output logic             done
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  seqState_t        state;
  logic [1:0]       phase;
  logic [BIT_W-1:0] bitCnt;
  ctrlReg_t         cfg;
  logic [PTR_W-1:0] nextPtr;
  logic             stopNow;
  logic             unusedWrBits;

  assign unusedWrBits = ^regWdata[7:4];

  assign regRdata = cfg;
  assign busy     = (state != ST_IDLE);
  assign csIdle   = cfg.csiv;
  assign sck      = (state == ST_SHIFT) && phase[1];

  assign strobe.load   = (state == ST_LOAD);
  assign strobe.sample = (state == ST_SHIFT) && (phase == 2'd1);
  assign strobe.shift  = (state == ST_SHIFT) && (phase == 2'd3);
  assign strobe.commit = (state == ST_FIN);

  always_comb begin
    if (ptr == cfg.endQ) nextPtr = cfg.wrto ? cfg.newQ : '0;
    else                 nextPtr = ptr + 1'b1;
    stopNow = cfg.halt || ((ptr == cfg.endQ) && !cfg.wren);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitCnt <= '0;
      ptr    <= '0;
      cfg    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (regWe) begin
        cfg.halt <= regWdata[15];
        cfg.wren <= regWdata[14];
        cfg.wrto <= regWdata[13];
        cfg.csiv <= regWdata[12];
        cfg.endQ <= regWdata[11:8];
        cfg.newQ <= regWdata[3:0];
      end
      unique case (state)
        ST_IDLE: begin
          if (start && !cfg.halt) begin
            ptr   <= cfg.newQ;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          phase  <= '0;
          bitCnt <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          cfg.cptQ <= ptr;
          if (stopNow) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            ptr   <= nextPtr;
            state <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_queue_datapath.sv
module spi_queue_datapath
  import spi_queue_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [PTR_W-1:0]   ptr,
  input  logic               busy,
  input  logic               csIdle,
  input  logic               ramWe,
  input  logic [PTR_W-1:0]   ramWaddr,
  input  logic [ENTRY_W-1:0] ramWdata,
  input  logic [PTR_W-1:0]   rxRaddr,
  output logic [DATA_W-1:0]  rxRdata,
  output logic               mosi,
  input  logic               miso,
  output logic [CS_W-1:0]    csOut
);
  logic [ENTRY_W-1:0] txRam [ENTRIES];
  logic [DATA_W-1:0]  rxRam [ENTRIES];
  logic [DATA_W-1:0]  txSh;
  logic [DATA_W-1:0]  rxSh;
  logic [CS_W-1:0]    csReg;
  logic               csValid;
  logic [ENTRY_W-1:0] curEntry;

  assign curEntry = txRam[ptr];
  assign mosi     = txSh[DATA_W-1];
  assign rxRdata  = rxRam[rxRaddr];
  assign csOut    = (busy && csValid) ? csReg : {CS_W{csIdle}};

  always_ff @(posedge clk) begin
    if (ramWe) txRam[ramWaddr] <= ramWdata;
    if (strobe.commit) rxRam[ptr] <= rxSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      csReg   <= '0;
      csValid <= 1'b0;
    end else begin
      if (strobe.load) begin
        txSh    <= curEntry[DATA_W-1:0];
        csReg   <= curEntry[ENTRY_W-1:DATA_W];
        csValid <= 1'b1;
      end else begin
        if (!busy) csValid <= 1'b0;
        if (strobe.shift) txSh <= {txSh[DATA_W-2:0], 1'b0};
      end
      if (strobe.sample) rxSh <= {rxSh[DATA_W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
  import spi_queue_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        ramWe,
  input  logic [3:0]  ramWaddr,
  input  logic [11:0] ramWdata,
  input  logic [3:0]  rxRaddr,
  output logic [7:0]  rxRdata,
  input  logic        start,
  output logic        done,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  csOut
);
  dpStrobe_t        strobe;
  logic [PTR_W-1:0] ptr;
  logic             busy;
  logic             csIdle;

  spi_queue_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .start(start), .strobe(strobe), .ptr(ptr),
    .busy(busy), .csIdle(csIdle), .sck(sck), .done(done)
  );

  spi_queue_datapath dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptr(ptr), .busy(busy),
    .csIdle(csIdle), .ramWe(ramWe), .ramWaddr(ramWaddr),
    .ramWdata(ramWdata), .rxRaddr(rxRaddr), .rxRdata(rxRdata),
    .mosi(mosi), .miso(miso), .csOut(csOut)
  );
endmodule

// File: rtl/spi_queue_chk.sv
module spi_queue_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        sck,
  input logic        done,
  input logic [3:0]  csOut,
  input logic [15:0] regRdata
);
  assert_cs_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csOut == {4{regRdata[12]}});

  assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  assert_sck_high_two_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |=> sck);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_cpt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(regRdata[7:4]));
endmodule

bind spi_queue_seq spi_queue_chk chkI (
  .clk(clk), .rstN(rstN), .busy(busy), .sck(sck), .done(done),
  .csOut(csOut), .regRdata(regRdata)
);

// File: tb/spi_queue_seq_test.sv
`timescale 1ns/1ps
module spi_queue_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        ramWe = 1'b0;
  logic [3:0]  ramWaddr = '0;
  logic [11:0] ramWdata = '0;
  logic [3:0]  rxRaddr = '0;
  logic [7:0]  rxRdata;
  logic        start = 1'b0;
  logic        done;
  logic        sck;
  logic        mosi;
  logic        miso;
  logic [3:0]  csOut;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int doneCnt = 0;
  int sentCnt = 0;
  int bitN = 0;
  logic [7:0] mosiSh = '0;
  logic [3:0] csAtFirst = '0;
  logic [7:0] wordLog [64];
  logic [3:0] csLog [64];

  always #10 clk = ~clk;

  spi_queue_seq uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .ramWe(ramWe), .ramWaddr(ramWaddr),
    .ramWdata(ramWdata), .rxRaddr(rxRaddr), .rxRdata(rxRdata),
    .start(start), .done(done), .sck(sck), .mosi(mosi), .miso(miso),
    .csOut(csOut)
  );

  function automatic logic [7:0] txData(input int e);
    logic [3:0] v = 4'(e);
    return {v, ~v};
  endfunction
  function automatic logic [3:0] csPat(input int e);
    return 4'(e) ^ 4'h5;
  endfunction
  function automatic logic [7:0] resp(input int k);
    return 8'h5A ^ 8'(k * 29);
  endfunction

  // slave model: answers transfer k with resp(k), MSB first
  assign miso = resp(sentCnt)[3'(7 - bitN)];

  always @(posedge sck) begin
    mosiSh = {mosiSh[6:0], mosi};
    if (bitN == 0) csAtFirst = csOut;
    bitN = bitN + 1;
    if (bitN == 8) begin
      if (sentCnt < 64) begin
        wordLog[sentCnt] = mosiSh;
        csLog[sentCnt] = csAtFirst;
      end
      sentCnt = sentCnt + 1;
      bitN = 0;
    end
  end

  always @(posedge clk) if (rstN && done) doneCnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input bit h, input bit wr, input bit wt, input bit cs,
                          input int endq, input int newq);
    @(negedge clk);
    regWe = 1'b1;
    regWdata = {h, wr, wt, cs, 4'(endq), 4'hF, 4'(newq)};
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    sentCnt = 0;
    bitN = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int d0 = doneCnt;
    int n = 0;
    while (doneCnt == d0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(doneCnt == d0 + 1, req, doneCnt - d0, 1);
  endtask

  function automatic int rxAt(input int e);
    return 0;
  endfunction

  task automatic readRx(input int e, output logic [7:0] v);
    @(negedge clk);
    rxRaddr = 4'(e);
    #1 v = rxRdata;
  endtask

  task automatic runQueue(input int newq, input int len, input bit cs);
    int endq = (newq + len - 1) % 16;
    logic [7:0] v;
    writeReg(1'b0, 1'b0, 1'b0, cs, endq, newq);
    pulseStart();
    waitDone("R11 done after linear queue");
    chk(sentCnt == len, "R3/R6 transfer count", sentCnt, len);
    for (int i = 0; i < len; i++) begin
      int e = (newq + i) % 16;
      chk(wordLog[i] == txData(e), "R3 mosi byte (R6 modulo order)", wordLog[i], txData(e));
      chk(csLog[i] == csPat(e), "R4 chip-select pattern", csLog[i], csPat(e));
      readRx(e, v);
      chk(v == resp(i), "R5 received byte", v, resp(i));
    end
    chk(regRdata[7:4] == 4'(endq), "R7 completed entry", regRdata[7:4], endq);
    chk(csOut == {4{cs}}, "R4 idle chip-select level", csOut, {4{cs}});
    chk(sck == 1'b0, "R3 sck idle low", sck, 0);
  endtask

  task automatic haltAfter(input int n);
    while (sentCnt < n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(regRdata == 16'h0000, "R1 control word reset", regRdata, 0);
    chk(csOut == 4'h0, "R1 csOut reset", csOut, 0);
    chk(sck == 1'b0 && done == 1'b0, "R1 sck/done reset", {sck, done}, 0);

    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      ramWe = 1'b1; ramWaddr = 4'(e); ramWdata = {csPat(e), txData(e)};
    end
    @(negedge clk);
    ramWe = 1'b0;

    // R2: layout read-back, completed field read-only
    writeReg(1'b0, 1'b1, 1'b1, 1'b1, 9, 6);
    chk(regRdata == 16'h7906, "R2 layout and read-only field", regRdata, 16'h7906);

    // sweep all start entries, lengths 1..3, both idle levels (R6 wraps past 15)
    for (int s = 0; s < 16; s++)
      for (int l = 1; l <= 3; l++)
        runQueue(s, l, 1'(s));

    // R8: wrap to entry 0, halted during transfer 5
    writeReg(1'b0, 1'b1, 1'b0, 1'b0, 4, 3);
    pulseStart();
    haltAfter(5);
    writeReg(1'b1, 1'b1, 1'b0, 1'b0, 4, 3);
    waitDone("R10 done after halt");
    chk(sentCnt == 5, "R10 halt after current transfer", sentCnt, 5);
    begin
      int expE[5] = '{3, 4, 0, 1, 2};
      for (int i = 0; i < 5; i++)
        chk(wordLog[i] == txData(expE[i]), "R8 wrap to entry zero order", wordLog[i], txData(expE[i]));
    end
    chk(regRdata[7:4] == 4'd2, "R7 completed entry after halt", regRdata[7:4], 2);

    // R10: start ignored while halt is set
    pulseStart();
    repeat (60) @(negedge clk);
    chk(sentCnt == 0, "R10 start ignored while halted", sentCnt, 0);

    // R9: wrap to first entry
    writeReg(1'b0, 1'b1, 1'b1, 1'b0, 7, 6);
    pulseStart();
    haltAfter(5);
    writeReg(1'b1, 1'b1, 1'b1, 1'b0, 7, 6);
    waitDone("R11 done after halt in wrap");
    chk(sentCnt == 5, "R10 halt count in wrap", sentCnt, 5);
    begin
      int expF[5] = '{6, 7, 6, 7, 6};
      for (int i = 0; i < 5; i++)
        chk(wordLog[i] == txData(expF[i]), "R9 wrap to first entry order", wordLog[i], txData(expF[i]));
    end

    // R10: clear halt and restart from first entry
    writeReg(1'b0, 1'b0, 1'b0, 1'b0, 12, 10);
    pulseStart();
    waitDone("R10 done after restart");
    chk(sentCnt == 3 && wordLog[0] == txData(10), "R10 restart from first entry",
        wordLog[0], txData(10));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule